// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose I/O controller. Each bit of its registers stands for one I/O line, so the register width also sets the number of lines. A simple synchronous register bus reaches five registers: a data register, a write-one-to-set register, a write-one-to-clear register, and two direction registers. The two direction registers are complementary views of one shared state. The block drives an output value and an output enable for each line. It samples the line inputs through a two-flop synchronizer.

Three build-time options adapt the bus view to the software that uses it:
- A separate set/clear pair can be present. Without it, the set register simply replaces the output values.
- Line numbering can be mirrored.
- Byte lanes can be swapped to big-endian order at 16-bit and 32-bit widths.

The mapping between the bus and the lines is applied the same way on writes and on reads. Internally all state is kept in line order.

Register offsets on `addr_i`:

| Offset | Register |
|---|---|
| 0 | data |
| 1 | set |
| 2 | clear |
| 3 | direction-out |
| 4 | direction-in |

Other offsets read as zero and ignore writes. A write takes effect at the clock edge where `we_i` is sampled. A read sampled at an edge presents its value on `rdata_o` after that edge, and it reflects the state from before any write in the same cycle.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: After reset, `pin_oe_o` and `pin_o` are all zero (every line an input). A read of direction-out returns 0, and a read of direction-in returns all ones.
- R2: Writing direction-out (offset 3) sets the output enables. A 1 makes the line an output. The next direction-in read returns the bitwise complement of the written value.
- R3: Writing direction-in (offset 4) sets the output enables to the complement of the written value. The next direction-out read returns that complement.
- R4: Writing the data register (offset 0) loads every line's output value directly into `pin_o`.
- R5: With the set/clear pair present, writing a 1 to a bit of the set register (offset 1) drives that line high. Bits written as 0 keep their value.
- R6: With the set/clear pair present, writing a 1 to a bit of the clear register (offset 2) drives that line low. Bits written as 0 keep their value. A read of the clear register returns 0.
- R7: A read of the set register returns the currently driven output values of all lines.
- R8: A read of the data register returns, per line, the driven value if the line is an output, and the synchronized pin level if it is an input.
- R9: A pin change is visible in a data read sampled at the third clock edge after the change, and not at the first or second.
- R10: With mirrored numbering and byte swap on at 32 bits, bus bit b maps to line 31 − (8·(3 − b/8) + b mod 8). For example, bus bit 0 controls line 7, and the same mapping applies to reads.
- R11: Without the set/clear pair, a set-register write replaces all output values, and a clear-register write leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | WIDTH | Write data, bus order |
| re_i | input | 1 | Read strobe |
| rdata_o | output | WIDTH | Read data, bus order, registered |
| pin_i | input | WIDTH | Line input levels, line order |
| pin_o | output | WIDTH | Line output values |
| pin_oe_o | output | WIDTH | Line output enables |

## Verification
Two instances share one bus:
- a plain build with the set/clear pair;
- a build with mirrored numbering and byte swap but no clear register.

Their differing results separate the update rules from the lane mapping. A single-bit data write isolates the lane permutation from any other effect. A mixed direction pattern combined with an alternating pin pattern shows that each line's read source follows its own enable. Three back-to-back data reads, issued across a pin change, pin down the synchronizer latency to the exact edge.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA    = 3'd0,
    REG_SET     = 3'd1,
    REG_CLR     = 3'd2,
    REG_DIR_OUT = 3'd3,
    REG_DIR_IN  = 3'd4
  } gpio_reg_e;

  // source bit for position i; byte swap and mirror commute and are involutions
  function automatic int lane_src(int i, int w, bit mirror, bit bswap);
    int idx;
    idx = i;
    if (bswap && (w == 16 || w == 32)) idx = 8 * (w / 8 - 1 - i / 8) + i % 8;
    if (mirror) idx = w - 1 - idx;
    return idx;
  endfunction
endpackage

// File: rtl/gpio_lane_map.sv
module gpio_lane_map #(
  parameter int WIDTH  = 32,
  parameter bit MIRROR = 1'b0,
  parameter bit BSWAP  = 1'b0
) (
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);
  import gpio_mmio_pkg::*;
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam int Src = lane_src(i, WIDTH, MIRROR, BSWAP);
    assign d_o[i] = d_i[Src];
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_reg_core.sv
module gpio_reg_core #(
  parameter int WIDTH      = 32,
  parameter bit HAS_SETCLR = 1'b1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [gpio_mmio_pkg::ADDR_W-1:0] addr_i,
  input  logic                             we_i,
  input  logic                             re_i,
  input  logic [WIDTH-1:0]                 wline_i,
  input  logic [WIDTH-1:0]                 sync_i,
  output logic [WIDTH-1:0]                 out_o,
  output logic [WIDTH-1:0]                 dir_o,
  output logic [WIDTH-1:0]                 rline_o
);
  import gpio_mmio_pkg::*;

  logic [WIDTH-1:0] out_q, dir_q, rd_q, rd_mux;

  always_comb begin
    unique case (addr_i)
      REG_DATA:    rd_mux = (out_q & dir_q) | (sync_i & ~dir_q);
      REG_SET:     rd_mux = out_q;
      REG_DIR_OUT: rd_mux = dir_q;
      REG_DIR_IN:  rd_mux = ~dir_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
      rd_q  <= '0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          REG_DATA:    out_q <= wline_i;
          REG_SET:     out_q <= HAS_SETCLR ? (out_q | wline_i) : wline_i;
          REG_CLR:     if (HAS_SETCLR) out_q <= out_q & ~wline_i;
          REG_DIR_OUT: dir_q <= wline_i;
          REG_DIR_IN:  dir_q <= ~wline_i;
          default: ;
        endcase
      end
      if (re_i) rd_q <= rd_mux;
    end
  end

  assign out_o   = out_q;
  assign dir_o   = dir_q;
  assign rline_o = rd_q;
endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl #(
  parameter int WIDTH      = 32,
  parameter bit HAS_SETCLR = 1'b1,
  parameter bit MIRROR     = 1'b0,
  parameter bit BSWAP      = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       addr_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o
);
  logic [WIDTH-1:0] wline, rline, sync_in;

  gpio_lane_map #(.WIDTH(WIDTH), .MIRROR(MIRROR), .BSWAP(BSWAP)) u_map_wr (
    .d_i(wdata_i), .d_o(wline)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync_in)
  );

  gpio_reg_core #(.WIDTH(WIDTH), .HAS_SETCLR(HAS_SETCLR)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .re_i(re_i),
    .wline_i(wline), .sync_i(sync_in), .out_o(pin_o), .dir_o(pin_oe_o),
    .rline_o(rline)
  );

  gpio_lane_map #(.WIDTH(WIDTH), .MIRROR(MIRROR), .BSWAP(BSWAP)) u_map_rd (
    .d_i(rline), .d_o(rdata_o)
  );
endmodule

// File: rtl/gpio_mmio_ctrl_chk.sv
module gpio_mmio_ctrl_chk #(
  parameter int WIDTH      = 32,
  parameter bit HAS_SETCLR = 1'b1,
  parameter bit MIRROR     = 1'b0,
  parameter bit BSWAP      = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       addr_i,
  input logic             we_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic             re_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic [WIDTH-1:0] pin_o,
  input logic [WIDTH-1:0] pin_oe_o
);
  import gpio_mmio_pkg::*;

  logic [WIDTH-1:0] w_line, oe_bus;

  gpio_lane_map #(.WIDTH(WIDTH), .MIRROR(MIRROR), .BSWAP(BSWAP)) u_cw (
    .d_i(wdata_i), .d_o(w_line)
  );
  gpio_lane_map #(.WIDTH(WIDTH), .MIRROR(MIRROR), .BSWAP(BSWAP)) u_co (
    .d_i(pin_oe_o), .d_o(oe_bus)
  );

  a_r2_dirout_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == REG_DIR_OUT) |=> rdata_o == $past(oe_bus));

  a_r3_dirin_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == REG_DIR_IN) |=> rdata_o == ~$past(oe_bus));

  a_r4_data_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_DATA) |=> pin_o == $past(w_line));

  a_r5_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_SETCLR && we_i && addr_i == REG_SET) |=>
      ((pin_o & $past(w_line)) == $past(w_line)) &&
      ((pin_o & ~$past(w_line)) == ($past(pin_o) & ~$past(w_line))));

  a_r6_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_SETCLR && we_i && addr_i == REG_CLR) |=>
      ((pin_o & $past(w_line)) == '0) &&
      ((pin_o & ~$past(w_line)) == ($past(pin_o) & ~$past(w_line))));

  a_r6_clr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == REG_CLR) |=> rdata_o == '0);

  a_r2_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pin_oe_o) && $stable(pin_o));
endmodule

bind gpio_mmio_ctrl gpio_mmio_ctrl_chk #(
  .WIDTH(WIDTH), .HAS_SETCLR(HAS_SETCLR), .MIRROR(MIRROR), .BSWAP(BSWAP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
  .wdata_i(wdata_i), .re_i(re_i), .rdata_o(rdata_o), .pin_o(pin_o),
  .pin_oe_o(pin_oe_o)
);

// File: tb/gpio_mmio_ctrl_tb.sv
module gpio_mmio_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [31:0] wdata_i = '0, pin_i = '0;
  logic [31:0] rdata_a, pin_a, oe_a, rdata_b, pin_b, oe_b;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_mmio_ctrl #(.WIDTH(32), .HAS_SETCLR(1), .MIRROR(0), .BSWAP(0)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .re_i(re_i), .rdata_o(rdata_a), .pin_i(pin_i),
    .pin_o(pin_a), .pin_oe_o(oe_a)
  );

  gpio_mmio_ctrl #(.WIDTH(32), .HAS_SETCLR(0), .MIRROR(1), .BSWAP(1)) u_dut_mb (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .re_i(re_i), .rdata_o(rdata_b), .pin_i(pin_i),
    .pin_o(pin_b), .pin_oe_o(oe_b)
  );

  // byte swap followed by bit reversal
  function automatic logic [31:0] bm(logic [31:0] x);
    logic [31:0] s, r;
    s = {x[7:0], x[15:8], x[23:16], x[31:24]};
    for (int i = 0; i < 32; i++) r[i] = s[31-i];
    return r;
  endfunction

  typedef struct {
    logic [31:0] ea;
    logic [31:0] eb;
    string       tag;
  } item_t;
  item_t sb_q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(logic [2:0] a, logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] ea, logic [31:0] eb, string tag);
    item_t it;
    it.ea = ea; it.eb = eb; it.tag = tag;
    sb_q.push_back(it);
    addr_i = a; re_i = 1'b1;
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  logic rd_seen = 1'b0;
  always @(posedge clk_i) rd_seen <= re_i;

  always @(negedge clk_i) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        check("scoreboard empty", 32'h0, 32'h1);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check({it.tag, " plain"}, rdata_a, it.ea);
        check({it.tag, " mirror-swap"}, rdata_b, it.eb);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] dir_b, out_b;
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 oe plain", oe_a, 32'h0);
    check("R1 oe mirror-swap", oe_b, 32'h0);
    check("R1 pin_o plain", pin_a, 32'h0);
    rd(3'd3, 32'h0, 32'h0, "R1 dir_out read");
    rd(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 dir_in read");

    // R2 direction-out write
    wr(3'd3, 32'h0000_FFFF);
    check("R2 oe plain", oe_a, 32'h0000_FFFF);
    check("R2 oe mirror-swap", oe_b, bm(32'h0000_FFFF));
    rd(3'd4, 32'hFFFF_0000, 32'hFFFF_0000, "R2 dir_in view");

    // R3 direction-in write
    wr(3'd4, 32'h00FF_00FF);
    check("R3 oe plain", oe_a, 32'hFF00_FF00);
    check("R3 oe mirror-swap", oe_b, bm(32'hFF00_FF00));
    rd(3'd3, 32'hFF00_FF00, 32'hFF00_FF00, "R3 dir_out view");

    // R10 lane mapping with single bit
    wr(3'd0, 32'h0000_0001);
    check("R10 single bit plain", pin_a, 32'h0000_0001);
    check("R10 single bit mirror-swap", pin_b, 32'h0000_0080);

    // R4 data load
    wr(3'd0, 32'h1234_5678);
    check("R4 pin_o plain", pin_a, 32'h1234_5678);
    check("R4 pin_o mirror-swap", pin_b, bm(32'h1234_5678));

    // R5 set, R11 replace on variant
    wr(3'd1, 32'h0000_0F00);
    check("R5 set plain", pin_a, 32'h1234_5F78);
    check("R11 set replaces", pin_b, bm(32'h0000_0F00));

    // R6 clear, R11 clear ignored
    wr(3'd2, 32'h0000_0078);
    check("R6 clear plain", pin_a, 32'h1234_5F00);
    check("R11 clear ignored", pin_b, bm(32'h0000_0F00));
    rd(3'd2, 32'h0, 32'h0, "R6 clear reads zero");

    // R7 set readback
    rd(3'd1, 32'h1234_5F00, 32'h0000_0F00, "R7 set readback");

    // R8 mixed direction data read
    pin_i = 32'hA5A5_A5A5;
    idle(3);
    dir_b = bm(32'hFF00_FF00);
    out_b = bm(32'h0000_0F00);
    rd(3'd0, 32'h12A5_5FA5, bm((out_b & dir_b) | (32'hA5A5_A5A5 & ~dir_b)),
       "R8 data mixed");

    // R9 synchronizer latency, all lines inputs
    wr(3'd3, 32'h0);
    pin_i = 32'h5555_0000;
    idle(4);
    pin_i = 32'hFFFF_FFFF;
    rd(3'd0, 32'h5555_0000, bm(32'h5555_0000), "R9 edge1 old");
    rd(3'd0, 32'h5555_0000, bm(32'h5555_0000), "R9 edge2 old");
    rd(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 edge3 new");

    idle(3);
    check("scoreboard drained", 32'(sb_q.size()), 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule